// File: doc/BRIEF.md
# Reconfigurable Viterbi Traceback Unit

This block rebuilds the survivor path of a Viterbi decoder by walking the trellis backwards through decision bits that an add-compare-select stage stored earlier, eight decisions per memory word. The trellis size is chosen at run time through the constraint length K, from 5 to 9, which gives 16 to 256 states. The window length is 6K stages, so one window holds 30 to 54 stages. The predecessor rule, the row stride in memory and the window length all follow K.

Two reverse walkers run side by side, and each one reads its own path memory. The warm-up walker starts from state 0 and walks the newer window. It produces no bits. Its only result is the state it reaches at the start of that window, which is a reliable state. The trace walker walks the older window and emits one decoded bit per stage. It is seeded with the state that the warm-up walker reached on the previous command, so the two walkers form a pipeline from one command to the next.

Decoded bits leave the block in reverse time order. Choosing the best final state and putting the bits back in time order are left to the surrounding logic.

Top module: `vit_traceback`

## Requirements
- R1: While reset is held and in the cycle after it is released, `bit_valid`, `done`, `trc_rd_en` and `warm_rd_en` are all 0.
- R2: When a command is accepted, both walkers drive their first memory read in the cycle that follows the edge which sampled `start`.
- R3: For a current state S of K-1 bits, the decoded bit is S[K-2]. The decision d is bit S[2:0] of the word read for S. The predecessor is ((S << 1) | d) with every bit from K-1 upward cleared.
- R4: The read address for state S at stage s is base + s * 2^(K-4) + (S >> 3). The stage counts down from 6K-1 to 0. A word is returned in the cycle after its address, and one stage is read per cycle.
- R5: The first decoded bit is valid in the cycle after the second edge following the edge that sampled `start`. Exactly 6K bits follow, in consecutive cycles.
- R6: `done` is a one-cycle pulse in the same cycle as the last valid decoded bit.
- R7: The warm-up walker starts every command from state 0. It reads its own memory with the addressing of R4 and `warm_base`, and it emits no bits.
- R8: The trace walker starts from the warm-up walker's final state of the previous command, or from 0 for the first command after reset. A command accepted in the cycle in which `done` is high already uses the state that has just been reached.
- R9: A `start` raised while a command is running is ignored. It changes neither the bit stream nor the number of bits, and it produces no extra run.
- R10: Every K from 5 to 9 works. State bits from K-1 upward stay 0, including when a seed left by a larger K is used with a smaller K.
- R11: The two walkers read their memories in exactly the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_k | input | 4 | Constraint length K (5..9), captured with `start` |
| start | input | 1 | Command strobe; accepted only when idle |
| trc_base | input | 11 | Base address of the older window in the trace memory |
| warm_base | input | 11 | Base address of the newer window in the warm-up memory |
| trc_rd_en | output | 1 | Trace memory read enable |
| trc_rd_addr | output | 11 | Trace memory read address |
| trc_rd_data | input | 8 | Trace memory word, one cycle after the address |
| warm_rd_en | output | 1 | Warm-up memory read enable |
| warm_rd_addr | output | 11 | Warm-up memory read address |
| warm_rd_data | input | 8 | Warm-up memory word, one cycle after the address |
| bit_out | output | 1 | Decoded bit, in reverse time order |
| bit_valid | output | 1 | `bit_out` is valid |
| done | output | 1 | Pulse with the last decoded bit of a window |

## Verification
The memories are filled with four patterns, and each one exposes a different fault:

- All-zero decisions drive every path to state 0, which shows whether the top bit is dropped when the state shifts.
- All-one decisions saturate the state at the K-dependent mask, which exposes any fault in the masking.
- Zero trace decisions combined with one warm-up decisions make every trace bit depend only on the seed handed over. This shows whether the warm-up result reaches the trace walker.
- Hashed contents exercise the bit select within a word and the address row stride for each K.

Commands are issued back to back, with a different K each time, and one is raised on the very cycle `done` is high. A stray `start` is also raised in the middle of a window. Together these separate the seed forwarding, the run-time reconfiguration and the way a busy walker ignores a new command.

// File: rtl/vtb_pkg.sv
package vtb_pkg;

    localparam int K_MIN    = 5;
    localparam int K_MAX    = 9;
    localparam int SW       = K_MAX - 1;                 // state register width
    localparam int DW       = 8;                         // decisions per word
    localparam int SEL_W    = $clog2(DW);                // bit-select width
    localparam int WIDX_W   = SW - SEL_W;                // word index width
    localparam int WLEN_MUL = 6;                         // window = 6 * K
    localparam int CW       = $clog2(WLEN_MUL * K_MAX + 1);
    localparam int SHIFT_W  = $clog2(K_MAX - SEL_W);     // row stride log2 range

    typedef logic [SW-1:0]      state_t;
    typedef logic [DW-1:0]      word_t;
    typedef logic [CW-1:0]      stage_t;
    typedef logic [3:0]         klen_t;
    typedef logic [WIDX_W-1:0]  widx_t;
    typedef logic [SHIFT_W-1:0] shamt_t;

    typedef enum logic [1:0] {
        W_IDLE,
        W_PRIME,
        W_RUN
    } phase_e;

    // Mask of the K-1 live state bits
    function automatic state_t mask_of(klen_t k);
        state_t m;
        for (int i = 0; i < SW; i++) begin
            m[i] = (i < int'(k) - 1);
        end
        return m;
    endfunction

    // log2 of words per trellis stage: 2^(K-1) / DW
    function automatic shamt_t wlog_of(klen_t k);
        return shamt_t'(int'(k) - 1 - SEL_W);
    endfunction

    function automatic stage_t wlen_of(klen_t k);
        return stage_t'(WLEN_MUL * int'(k));
    endfunction

    function automatic state_t pred_of(state_t s, logic d, klen_t k);
        return {s[SW-2:0], d} & mask_of(k);
    endfunction

    function automatic widx_t word_of(state_t s);
        return widx_t'(s >> SEL_W);
    endfunction

    function automatic logic msb_of(state_t s, klen_t k);
        logic [$clog2(SW)-1:0] idx;
        idx = ($clog2(SW))'(int'(k) - 2);
        return s[idx];
    endfunction

endpackage

// File: rtl/vtb_addr.sv
module vtb_addr
    import vtb_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic [ADDR_W-1:0] base,
    input  stage_t            stage,
    input  shamt_t            wlog,
    input  widx_t             widx,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] row;

    assign row  = ADDR_W'(stage) << wlog;
    assign addr = base + row + ADDR_W'(widx);

endmodule

// File: rtl/vtb_walker.sv
module vtb_walker
    import vtb_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  klen_t             k_in,
    input  logic [ADDR_W-1:0] base_in,
    input  state_t            seed,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  word_t             rd_data,
    output logic              step_v,
    output logic              step_bit,
    output logic              last,
    output state_t            cur_state,
    output logic              busy
);

    phase_e            phase;
    state_t            st;
    stage_t            stage;
    klen_t             k_q;
    logic [ADDR_W-1:0] base_q;

    logic   dec;
    state_t nxt;
    stage_t stage_sel;
    widx_t  widx_sel;

    // decision of the current state, then its predecessor
    assign dec = rd_data[st[SEL_W-1:0]];
    assign nxt = pred_of(st, dec, k_q);

    // prime fetches the current state's own word; run fetches the
    // predecessor's word, whose index does not depend on the decision
    assign stage_sel = (phase == W_RUN) ? stage - stage_t'(1) : stage;
    assign widx_sel  = (phase == W_RUN) ? word_of(pred_of(st, 1'b0, k_q))
                                        : word_of(st);

    vtb_addr #(.ADDR_W(ADDR_W)) u_addr (
        .base  (base_q),
        .stage (stage_sel),
        .wlog  (wlog_of(k_q)),
        .widx  (widx_sel),
        .addr  (rd_addr)
    );

    assign rd_en     = (phase == W_PRIME) || ((phase == W_RUN) && (stage != '0));
    assign busy      = (phase != W_IDLE);
    assign cur_state = st;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= W_IDLE;
            st       <= '0;
            stage    <= '0;
            k_q      <= klen_t'(K_MIN);
            base_q   <= '0;
            step_v   <= 1'b0;
            step_bit <= 1'b0;
            last     <= 1'b0;
        end else begin
            step_v <= 1'b0;
            last   <= 1'b0;
            unique case (phase)
                W_IDLE: begin
                    if (go) begin
                        k_q    <= k_in;
                        base_q <= base_in;
                        st     <= seed & mask_of(k_in);
                        stage  <= wlen_of(k_in) - stage_t'(1);
                        phase  <= W_PRIME;
                    end
                end
                W_PRIME: phase <= W_RUN;
                W_RUN: begin
                    step_v   <= 1'b1;
                    step_bit <= msb_of(st, k_q);
                    st       <= nxt;
                    if (stage == '0) begin
                        phase <= W_IDLE;
                        last  <= 1'b1;
                    end else begin
                        stage <= stage - stage_t'(1);
                    end
                end
                default: phase <= W_IDLE;
            endcase
        end
    end

    // per-window step counter used by the count check
    logic [CW:0] vcount;
    always_ff @(posedge clk) begin
        if (rst) begin
            vcount <= '0;
        end else if (phase == W_IDLE && go) begin
            vcount <= '0;
        end else if (step_v) begin
            vcount <= vcount + 1'b1;
        end
    end

    // R10
    state_mask_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> ((st & ~mask_of(k_q)) == '0));

    // R5
    bit_run_chk: assert property (@(posedge clk) disable iff (rst)
        (step_v && !last) |=> step_v);

    // R5
    bit_count_chk: assert property (@(posedge clk) disable iff (rst)
        last |-> (int'(vcount) + 1 == int'(wlen_of(k_q))));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(k_q) && $stable(base_q)));

endmodule

// File: rtl/vit_traceback.sv
module vit_traceback
    import vtb_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        cfg_k,
    input  logic              start,
    input  logic [ADDR_W-1:0] trc_base,
    input  logic [ADDR_W-1:0] warm_base,
    output logic              trc_rd_en,
    output logic [ADDR_W-1:0] trc_rd_addr,
    input  logic [DW-1:0]     trc_rd_data,
    output logic              warm_rd_en,
    output logic [ADDR_W-1:0] warm_rd_addr,
    input  logic [DW-1:0]     warm_rd_data,
    output logic              bit_out,
    output logic              bit_valid,
    output logic              done
);

    logic   go;
    logic   trc_busy;
    logic   trc_last;
    state_t trc_state_unused;
    logic   warm_step_v;
    logic   warm_bit_unused;
    logic   warm_last;
    state_t warm_state;
    logic   warm_busy_unused;
    state_t seed_q;
    state_t seed_in;

    assign go = start && !trc_busy;

    // hand-over: take the fresh warm-up result if it lands this cycle
    assign seed_in = warm_last ? warm_state : seed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seed_q <= '0;
        end else if (warm_last) begin
            seed_q <= warm_state;
        end
    end

    vtb_walker #(.ADDR_W(ADDR_W)) u_trc (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .k_in      (cfg_k),
        .base_in   (trc_base),
        .seed      (seed_in),
        .rd_en     (trc_rd_en),
        .rd_addr   (trc_rd_addr),
        .rd_data   (trc_rd_data),
        .step_v    (bit_valid),
        .step_bit  (bit_out),
        .last      (trc_last),
        .cur_state (trc_state_unused),
        .busy      (trc_busy)
    );

    vtb_walker #(.ADDR_W(ADDR_W)) u_warm (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .k_in      (cfg_k),
        .base_in   (warm_base),
        .seed      ('0),
        .rd_en     (warm_rd_en),
        .rd_addr   (warm_rd_addr),
        .rd_data   (warm_rd_data),
        .step_v    (warm_step_v),
        .step_bit  (warm_bit_unused),
        .last      (warm_last),
        .cur_state (warm_state),
        .busy      (warm_busy_unused)
    );

    assign done = trc_last;

    // R11
    lockstep_chk: assert property (@(posedge clk) disable iff (rst)
        (trc_rd_en == warm_rd_en) && (bit_valid == warm_step_v));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    done_with_bit_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> bit_valid);

    // R8
    seed_end_chk: assert property (@(posedge clk) disable iff (rst)
        warm_last |-> trc_last);

endmodule

// File: tb/tb_vit_traceback.sv
module tb_vit_traceback;
    import vtb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 11;
    localparam int RAM_DEPTH  = 1 << ADDR_W;
    localparam int WD_CYCLES  = 20000;

    logic              clk;
    logic              rst;
    logic [3:0]        cfg_k;
    logic              start;
    logic [ADDR_W-1:0] trc_base;
    logic [ADDR_W-1:0] warm_base;
    logic              trc_rd_en;
    logic [ADDR_W-1:0] trc_rd_addr;
    logic [DW-1:0]     trc_rd_data;
    logic              warm_rd_en;
    logic [ADDR_W-1:0] warm_rd_addr;
    logic [DW-1:0]     warm_rd_data;
    logic              bit_out;
    logic              bit_valid;
    logic              done;

    logic [7:0] mem_t [RAM_DEPTH];
    logic [7:0] mem_w [RAM_DEPTH];

    int bit_q[$];
    int taddr_q[$];
    int waddr_q[$];
    int n_chk;
    int n_bad;
    int exp_seed;

    vit_traceback #(.ADDR_W(ADDR_W)) dut (
        .clk          (clk),
        .rst          (rst),
        .cfg_k        (cfg_k),
        .start        (start),
        .trc_base     (trc_base),
        .warm_base    (warm_base),
        .trc_rd_en    (trc_rd_en),
        .trc_rd_addr  (trc_rd_addr),
        .trc_rd_data  (trc_rd_data),
        .warm_rd_en   (warm_rd_en),
        .warm_rd_addr (warm_rd_addr),
        .warm_rd_data (warm_rd_data),
        .bit_out      (bit_out),
        .bit_valid    (bit_valid),
        .done         (done)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // path memories, one cycle read latency
    always @(posedge clk) begin
        if (trc_rd_en)  trc_rd_data  <= mem_t[trc_rd_addr];
        if (warm_rd_en) warm_rd_data <= mem_w[warm_rd_addr];
    end

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // 0: all zero, 1: all one, 2: hashed, 3: trace zero / warm-up one
    task automatic fill(input int pat, input int salt);
        for (int a = 0; a < RAM_DEPTH; a++) begin
            case (pat)
                0: begin mem_t[a] = 8'h00; mem_w[a] = 8'h00; end
                1: begin mem_t[a] = 8'hFF; mem_w[a] = 8'hFF; end
                3: begin mem_t[a] = 8'h00; mem_w[a] = 8'hFF; end
                default: begin
                    mem_t[a] = 8'((a * 73 + salt * 29 + (a >> 4) * 13) ^ (a >> 1));
                    mem_w[a] = 8'((a * 151 + salt * 7 + 17) ^ (a >> 3));
                end
            endcase
        end
    endtask

    // expected walk from the requirements (R3, R4, R7)
    task automatic model_walk(input int k, input int base, input int seed,
                              input bit trc, output int fin);
        int m;
        int s;
        m = (1 << (k - 1)) - 1;
        s = seed & m;
        for (int stg = 6 * k - 1; stg >= 0; stg--) begin
            int a;
            int w;
            int d;
            a = (base + stg * (1 << (k - 4)) + (s >> 3)) & (RAM_DEPTH - 1);
            if (trc) begin
                w = int'(mem_t[a]);
                taddr_q.push_back(a);
                bit_q.push_back((s >> (k - 2)) & 1);
            end else begin
                w = int'(mem_w[a]);
                waddr_q.push_back(a);
            end
            d = (w >> (s & 7)) & 1;
            s = ((s << 1) | d) & m;
        end
        fin = s;
    endtask

    // monitor: pops the scoreboard queues as results appear
    always @(negedge clk) begin
        int e;
        if (!rst) begin
            if (bit_valid) begin
                if (bit_q.size() == 0) begin
                    check(1'b0, "R9 spurious decoded bit", 1, 0);
                end else begin
                    e = bit_q.pop_front();
                    check(int'(bit_out) == e, "R3 R8 R10 decoded bit", int'(bit_out), e);
                end
            end
            if (done) begin
                check(bit_valid && bit_q.size() == 0, "R6 done with last bit",
                      bit_q.size(), 0);
            end
            if (trc_rd_en) begin
                if (taddr_q.size() == 0) begin
                    check(1'b0, "R4 unexpected trace read", int'(trc_rd_addr), -1);
                end else begin
                    e = taddr_q.pop_front();
                    check(int'(trc_rd_addr) == e, "R4 trace address", int'(trc_rd_addr), e);
                end
            end
            if (warm_rd_en) begin
                if (waddr_q.size() == 0) begin
                    check(1'b0, "R7 unexpected warm-up read", int'(warm_rd_addr), -1);
                end else begin
                    e = waddr_q.pop_front();
                    check(int'(warm_rd_addr) == e, "R7 warm-up address", int'(warm_rd_addr), e);
                end
            end
            if (trc_rd_en != warm_rd_en) begin
                check(1'b0, "R11 lockstep reads", int'(trc_rd_en), int'(warm_rd_en));
            end
        end
    end

    // driver: pushes expected items, then issues the command
    task automatic run_cmd(input int k, input int tb_base, input int wb_base,
                           input bit mid, input bit now, input int gap);
        int fin_w;
        int fin_t;
        if (now) #1;
        else @(negedge clk);
        model_walk(k, wb_base, 0, 1'b0, fin_w);
        model_walk(k, tb_base, exp_seed, 1'b1, fin_t);
        start     = 1'b1;
        cfg_k     = 4'(k);
        trc_base  = ADDR_W'(tb_base);
        warm_base = ADDR_W'(wb_base);
        @(negedge clk);
        start = 1'b0;
        check(trc_rd_en && warm_rd_en, "R2 first read after start", int'(trc_rd_en), 1);
        @(negedge clk);
        check(!bit_valid, "R5 no bit before latency", int'(bit_valid), 0);
        @(negedge clk);
        check(bit_valid, "R5 first bit latency", int'(bit_valid), 1);
        if (mid) begin
            repeat (4) @(negedge clk);
            start     = 1'b1;
            cfg_k     = 4'd5;
            trc_base  = '0;
            warm_base = '0;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        #1;
        check(bit_q.size() == 0, "R5 window length", bit_q.size(), 0);
        exp_seed = fin_w;
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        n_chk     = 0;
        n_bad     = 0;
        exp_seed  = 0;
        rst       = 1'b1;
        start     = 1'b0;
        cfg_k     = 4'd5;
        trc_base  = '0;
        warm_base = '0;
        fill(0, 0);
        repeat (4) @(negedge clk);
        check(!bit_valid && !done && !trc_rd_en && !warm_rd_en,
              "R1 outputs in reset", int'(bit_valid) + int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!bit_valid && !done && !trc_rd_en && !warm_rd_en,
              "R1 outputs after reset", int'(trc_rd_en) + int'(warm_rd_en), 0);

        run_cmd(5, 0, 0, 1'b0, 1'b0, 3);          // zero decisions, smallest K
        fill(2, 1);
        run_cmd(9, 100, 300, 1'b0, 1'b0, 3);      // hashed, largest K
        fill(1, 0);
        run_cmd(7, 500, 40, 1'b0, 1'b0, 3);       // R10 large seed masked to K=7
        fill(3, 0);
        run_cmd(6, 7, 9, 1'b1, 1'b0, 0);          // R9 stray start mid window
        run_cmd(8, 50, 60, 1'b0, 1'b1, 3);        // R8 start while done is high
        fill(2, 5);
        run_cmd(5, 1000, 1500, 1'b0, 1'b0, 3);    // R10 K=8 seed into K=5
        run_cmd(9, 319, 0, 1'b0, 1'b0, 6);        // top of the memory

        check(bit_q.size() == 0 && taddr_q.size() == 0 && waddr_q.size() == 0,
              "R9 no extra run", bit_q.size() + taddr_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", WD_CYCLES, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule